// File: doc/BRIEF.md
# Programmable Interval Clock

The block is a bus-attached interval timer with four word-sized register slots: a control/status word, a count-set buffer, the live counter, and one slot that reads zero. Software loads an interval into the buffer (which also loads the counter), picks one of four tick-enable inputs as the time base, chooses the count direction and single or repeating operation, and sets the run bit. The counter advances on every cycle in which the selected tick-enable input is high.

When the interval runs out, the block sets a done flag, or an overrun flag if done is still pending from the last interval. It raises an interrupt request if interrupts are enabled. In repeating operation the counter reloads from the buffer and keeps going. In single operation the run bit drops. A strobed read of the control/status word returns its value and then clears both flags and the interrupt. A write to the control/status word or to the buffer also clears them.

Top module: `interval_clock`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The `regAddr` slots decode as follows. Slot 0 is the control/status word, slot 1 is the buffer and slot 2 is the live counter. Slot 3 always reads zero, and writes to slots 2 and 3 change nothing.
- R3: The control/status word bits are: bit 0 run, bits 2:1 rate select, bit 3 repeat (1) or single (0), bit 4 count up (1) or down (0), bit 5 single-tick, bit 6 interrupt enable, bit 7 done and bit 15 overrun. Bit 5 and bits 14:8 read as zero.
- R4: `byteEn[0]` gates bits 7:0 of a write and `byteEn[1]` gates bits 15:8.
- R5: A buffer write stores the value, loads the merged value into the counter, and clears done, overrun and `irq`. It does not start or stop counting.
- R6: While run is set, only `tickEn[rate]` advances the counter. The other three inputs have no effect.
- R7: While run is clear, ticks are ignored and the counter holds its value.
- R8: When counting down from a loaded value N, expiry comes on tick N. N = 0 means 65536 ticks. The counter reads zero after expiry.
- R9: When counting up from N, expiry comes on the tick that wraps the counter from 0xFFFF to 0, which is 65536 − N ticks.
- R10: On expiry, overrun is set if done is already set; otherwise done is set. If interrupt enable is set, `irq` goes high and stays high until a clearing access.
- R11: On expiry in repeat mode, the counter reloads from the buffer. In single mode, the run bit clears.
- R12: A read strobe on slot 0 returns the current word, then clears done, overrun and `irq`.
- R13: A control/status write with `byteEn[0]` loads bits 6:0, except that bit 5 is not stored. Any control/status write clears done, overrun and `irq`.
- R14: A control/status write with bits 5 and 0 both set advances the counter by exactly one tick. Counter-tick inputs are ignored in any cycle that writes slot 0 or slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register slot select |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (carries side effects) |
| byteEn | input | 2 | Byte enables for writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the addressed slot (combinational) |
| tickEn | input | 4 | One tick-enable per rate source |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the interval boundaries first. A down count of zero must take the full 65536 ticks, and an up count from 0xFFFD must take 3 ticks. A design with an off-by-one compare would signal done one tick early or late, or at once on a zero load. Overrun is checked by letting a repeating interval expire twice without a read: a design that re-sets done instead would never show bit 15, and one that fails to reload would stall at zero. The bench also steers ticks onto the three unselected inputs, pulses the single-tick bit and writes the upper byte alone. A wrong rate multiplexer, a stored single-tick bit or byte enables that leak across the two halves each show up as a wrong counter or buffer value.

// File: rtl/ivclk_pkg.sv
package ivclk_pkg;
  typedef struct packed {
    logic       loadBuf;
    logic [1:0] byteSel;
    logic       tick;
    logic       countUp;
    logic       reload;
  } strobe_t;

  localparam int SLOT_CSR = 0;
  localparam int SLOT_BUF = 1;
  localparam int SLOT_CNT = 2;
endpackage

// File: rtl/ivclk_dpath.sv
module ivclk_dpath
  import ivclk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] bufVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              expire
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] bufReg, cntReg, bufMerged, cntNext;

  always_comb begin
    bufMerged = bufReg;
    if (strb.byteSel[0]) bufMerged[HALF-1:0] = wrData[HALF-1:0];
    if (strb.byteSel[1]) bufMerged[DATA_W-1:HALF] = wrData[DATA_W-1:HALF];
  end

  assign expire = strb.tick && (strb.countUp ? (cntReg == ALL_ONES) : (cntReg == ONE));

  always_comb begin
    cntNext = cntReg;
    if (strb.loadBuf)
      cntNext = bufMerged;
    else if (strb.tick) begin
      if (expire && strb.reload) cntNext = bufReg;
      else if (strb.countUp)     cntNext = cntReg + ONE;
      else                       cntNext = cntReg - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg <= '0;
      cntReg <= '0;
    end else begin
      if (strb.loadBuf) bufReg <= bufMerged;
      cntReg <= cntNext;
    end
  end

  assign bufVal = bufReg;
  assign cntVal = cntReg;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.loadBuf) |=> $stable(cntReg)); // R7
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strb.reload && !strb.loadBuf) |=> (cntReg == $past(bufReg))); // R11
endmodule

// File: rtl/ivclk_ctrl.sv
module ivclk_ctrl
  import ivclk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int N_RATES = 4,
  localparam int RATE_W = $clog2(N_RATES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        byteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_RATES-1:0] tickEn,
  input  logic              expire,
  output strobe_t           strb,
  output logic [DATA_W-1:0] csrVal,
  output logic              irq
);
  localparam int B_GO   = 0;
  localparam int B_RATE = 1;
  localparam int B_MODE = B_RATE + RATE_W;
  localparam int B_UP   = B_MODE + 1;
  localparam int B_FIX  = B_UP + 1;
  localparam int B_IE   = B_FIX + 1;
  localparam int B_DONE = B_IE + 1;
  localparam int B_ERR  = DATA_W - 1;

  logic              go, mode, up, ie, done, err, irqReg;
  logic [RATE_W-1:0] rate;
  logic csrWr, csrWrLo, bufWr, csrRd, clrFlags;
  logic goEff, modeEff, upEff, ieEff, doneEff, fixTick, runTick;
  logic [RATE_W-1:0] rateEff;

  assign csrWr   = regWr && (regAddr == 2'(SLOT_CSR));
  assign csrWrLo = csrWr && byteEn[0];
  assign bufWr   = regWr && (regAddr == 2'(SLOT_BUF));
  assign csrRd   = regRd && !regWr && (regAddr == 2'(SLOT_CSR));
  assign clrFlags = csrRd || csrWr || bufWr;

  assign goEff   = csrWrLo ? wrData[B_GO] : go;
  assign modeEff = csrWrLo ? wrData[B_MODE] : mode;
  assign upEff   = csrWrLo ? wrData[B_UP] : up;
  assign ieEff   = csrWrLo ? wrData[B_IE] : ie;
  assign rateEff = csrWrLo ? wrData[B_RATE +: RATE_W] : rate;
  assign doneEff = clrFlags ? 1'b0 : done;

  assign fixTick = csrWrLo && wrData[B_FIX] && wrData[B_GO];
  assign runTick = go && tickEn[rate] && !csrWr && !bufWr;

  always_comb begin
    strb         = '0;
    strb.loadBuf = bufWr;
    strb.byteSel = byteEn;
    strb.tick    = fixTick || runTick;
    strb.countUp = upEff;
    strb.reload  = modeEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      go <= 1'b0; mode <= 1'b0; up <= 1'b0; ie <= 1'b0;
      rate <= '0; done <= 1'b0; err <= 1'b0; irqReg <= 1'b0;
    end else begin
      go   <= goEff;
      mode <= modeEff;
      up   <= upEff;
      ie   <= ieEff;
      rate <= rateEff;
      if (expire && !modeEff) go <= 1'b0;
      done   <= doneEff || (expire && !doneEff);
      err    <= (clrFlags ? 1'b0 : err) || (expire && doneEff);
      irqReg <= (clrFlags ? 1'b0 : irqReg) || (expire && ieEff);
    end
  end

  always_comb begin
    csrVal = '0;
    csrVal[B_GO] = go;
    csrVal[B_RATE +: RATE_W] = rate;
    csrVal[B_MODE] = mode;
    csrVal[B_UP] = up;
    csrVal[B_IE] = ie;
    csrVal[B_DONE] = done;
    csrVal[B_ERR] = err;
  end

  assign irq = irqReg;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (csrRd && !expire) |=> (!done && !err && !irq)); // R12
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (expire && done && !clrFlags) |=> err); // R10
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ie); // R10
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !mode && !csrWr) |=> !go); // R11
  AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr || (csrWr && !fixTick)) |-> !strb.tick); // R14
endmodule

// File: rtl/interval_clock.sv
module interval_clock
  import ivclk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int N_RATES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        byteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [N_RATES-1:0] tickEn,
  output logic              irq
);
  strobe_t           strb;
  logic              expire;
  logic [DATA_W-1:0] csrVal, bufVal, cntVal;

  ivclk_ctrl #(.DATA_W(DATA_W), .N_RATES(N_RATES)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .byteEn(byteEn), .wrData(wrData), .tickEn(tickEn), .expire(expire),
    .strb(strb), .csrVal(csrVal), .irq(irq)
  );

  ivclk_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .bufVal(bufVal), .cntVal(cntVal), .expire(expire)
  );

  always_comb begin
    case (regAddr)
      2'(SLOT_CSR): rdData = csrVal;
      2'(SLOT_BUF): rdData = bufVal;
      2'(SLOT_CNT): rdData = cntVal;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: tb/sim_interval_clock.sv
module sim_interval_clock;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [1:0]  byteEn = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  tickEn = '0;
  logic        irq;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  interval_clock u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .tickEn(tickEn), .irq(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk); regAddr = a; byteEn = be; wrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0; byteEn = '0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] d);
    regAddr = a; #1; d = rdData;
  endtask

  task automatic rdStrobe(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1; d = rdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic ticks(int k, int n);
    @(negedge clk); tickEn = 4'b1 << k;
    repeat (n) @(negedge clk);
    tickEn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(0, v); chk("R1 csr", v, 16'h0000);
    peek(1, v); chk("R1 buf", v, 16'h0000);
    peek(2, v); chk("R1 cnt", v, 16'h0000);
    chk("R1 irq", irq, 0);

    // R8 down count 3, single, IE
    wr(1, 2'b11, 16'd3);
    peek(2, v); chk("R5 load cnt", v, 16'd3);
    wr(0, 2'b11, 16'h0041);
    ticks(0, 2);
    peek(2, v); chk("R8 cnt after 2", v, 16'd1);
    peek(0, v); chk("R8 not done yet", v, 16'h0041);
    ticks(0, 1);
    peek(2, v); chk("R8 cnt zero", v, 16'd0);
    peek(0, v); chk("R11 single clears run, R10 done", v, 16'h00C0);
    chk("R10 irq", irq, 1);
    rdStrobe(0, v); chk("R12 read value", v, 16'h00C0);
    peek(0, v); chk("R12 flags cleared", v, 16'h0040);
    chk("R12 irq cleared", irq, 0);

    // R10 R11 overrun in repeat mode
    wr(1, 2'b11, 16'd2);
    wr(0, 2'b11, 16'h0049);
    ticks(0, 2);
    peek(2, v); chk("R11 reload", v, 16'd2);
    peek(0, v); chk("R10 done", v, 16'h00C9);
    ticks(0, 2);
    peek(0, v); chk("R10 overrun", v, 16'h80C9);
    chk("R10 irq held", irq, 1);
    wr(1, 2'b11, 16'd2);
    peek(0, v); chk("R5 buf write clears flags", v, 16'h0049);
    chk("R5 irq cleared", irq, 0);
    ticks(0, 2);
    chk("R10 irq again", irq, 1);
    wr(0, 2'b10, 16'h0000);
    peek(0, v); chk("R13 upper write clears flags", v, 16'h0049);
    chk("R13 irq cleared", irq, 0);
    wr(0, 2'b11, 16'h0000);

    // R9 up count from FFFD
    wr(1, 2'b11, 16'hFFFD);
    wr(0, 2'b11, 16'h0011);
    ticks(0, 2);
    peek(2, v); chk("R9 cnt FFFF", v, 16'hFFFF);
    peek(0, v); chk("R9 not done", v, 16'h0011);
    ticks(0, 1);
    peek(0, v); chk("R9 done", v, 16'h0090);
    peek(2, v); chk("R9 wrapped", v, 16'h0000);
    chk("R10 no irq without IE", irq, 0);

    // R6 rate select
    wr(1, 2'b11, 16'd5);
    wr(0, 2'b11, 16'h0005);
    ticks(0, 3); ticks(1, 3); ticks(3, 3);
    peek(2, v); chk("R6 other rates ignored", v, 16'd5);
    ticks(2, 1);
    peek(2, v); chk("R6 selected rate", v, 16'd4);
    // R7 run clear holds
    wr(0, 2'b11, 16'h0004);
    ticks(2, 3);
    peek(2, v); chk("R7 hold", v, 16'd4);
    // R14 single tick
    wr(0, 2'b11, 16'h0025);
    peek(2, v); chk("R14 single tick", v, 16'd3);
    peek(0, v); chk("R13 bit5 not stored", v, 16'h0005);
    wr(0, 2'b11, 16'h0004);
    // R4 byte enables
    wr(1, 2'b10, 16'hAB77);
    peek(1, v); chk("R4 upper byte buf", v, 16'hAB05);
    peek(2, v); chk("R4 upper byte cnt", v, 16'hAB05);
    wr(1, 2'b01, 16'h1122);
    peek(1, v); chk("R4 lower byte buf", v, 16'hAB22);
    // R2 read-only slots
    wr(2, 2'b11, 16'h1234);
    peek(2, v); chk("R2 cnt write ignored", v, 16'hAB22);
    wr(3, 2'b11, 16'h5678);
    peek(3, v); chk("R2 slot3 zero", v, 16'h0000);
    wr(0, 2'b11, 16'hFF80);
    peek(0, v); chk("R3 unwritable bits", v, 16'h0000);

    // R8 zero means 65536
    wr(1, 2'b11, 16'd0);
    wr(0, 2'b11, 16'h0001);
    ticks(0, 65535);
    peek(2, v); chk("R8 zero cnt at 65535", v, 16'd1);
    peek(0, v); chk("R8 zero not done", v, 16'h0001);
    ticks(0, 1);
    peek(0, v); chk("R8 zero done at 65536", v, 16'h0080);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule